// File: doc/BRIEF.md
# Level Interrupt Controller with Queued Timer Ticks

This block gathers 32 level-style interrupt sources into one status word, masks them with a software-written enable word, and raises a single combined interrupt toward the CPU while any enabled status bit is set. Each source has a set pulse and a clear pulse. A clear pulse on a source acts as its acknowledge.

Source 9 belongs to an internal periodic timer. A clock divider produces the timer ticks at a fixed rate, 100 per second by default, derived from the input clock frequency. Each tick adds one to a saturating pending counter. A separate evaluation strobe copies "timer enabled and ticks pending" into status bit 9 and into a timer flag output. An acknowledge on source 9 removes exactly one pending tick. As a result, ticks that pile up while software is busy are serviced one by one, and the timer line comes back after each acknowledge until the backlog is gone. Source 10, the second timer, is treated as an ordinary external source.

Top module: `tick_queue_intc`

## Requirements
- R1: While reset is active, and in the cycle after it, the status word, the enable word and the pending count are zero, and `cpu_irq` and `tmr0_flag` are low.
- R2: For every source other than 9 (source 10 included), a set pulse makes its status bit 1 at the next clock edge, and a clear pulse makes it 0. When set and clear arrive together, set wins.
- R3: `cpu_irq` is high exactly when the bitwise AND of the status word and the enable word is nonzero. It changes in the same cycle that either register changes.
- R4: `reg_sel` = 0 reads the status word on `reg_rdata` and `reg_sel` = 1 reads the enable word, both combinationally. A write with `reg_sel` = 1 loads the enable word at the next edge. A write with `reg_sel` = 0 changes nothing.
- R5: A timer tick occurs once every CLK_HZ/TICK_HZ cycles, the first in the cycle that completes that many cycles after reset. Each tick adds one to the pending count, whether or not the timer is enabled.
- R6: The pending count is PEND_W bits wide and holds at its maximum when a tick arrives with no acknowledge. It never wraps to zero.
- R7: Every EVAL_DIV cycles an evaluation strobe sets status bit 9 and `tmr0_flag` to (`tmr0_en` AND pending count nonzero), using the count before that edge. `tmr0_flag` holds its value between strobes.
- R8: A clear pulse on source 9 takes one off the pending count only if the count is nonzero. A tick and an acknowledge in the same cycle leave a nonzero count unchanged. The acknowledge also clears status bit 9 unless an evaluation strobe falls in the same cycle, in which case the strobe decides.
- R9: A set pulse on source 9 has no effect. That status bit is owned by the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 32 | Per-source set pulses |
| src_clr | input | 32 | Per-source clear / acknowledge pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| tmr0_en | input | 1 | Timer-0 enable |
| tmr0_flag | output | 1 | Timer-0 status flag, updated on each evaluation strobe |
| cpu_irq | output | 1 | Combined interrupt to the CPU |

## Verification
The bench drives a long run with no acknowledges so that the pending count reaches its ceiling. It then drains the count one acknowledge per cycle. A counter that wrapped would drop the timer flag hundreds of cycles early, and one that ignored acknowledges at zero would underflow and hold the line up forever. Simultaneous set and clear on one source, simultaneous tick and acknowledge, and acknowledges that land on an evaluation strobe are all hit. A wrong priority shows up as a status bit or flag that differs from the model by one cycle. Writes aimed at the status word and set pulses on the timer source are also issued; a design that honoured either would show a status bit the model does not have.

// File: rtl/intc_pkg.sv
// Shared constants and types for the queued-tick interrupt controller.
// Assumes a fixed source count; the timer source index is decoded by the
// status register, so it is kept here as the single point of truth.
package intc_pkg;
    localparam int NSRC     = 32;
    localparam int TMR0_SRC = 9;
    localparam int TMR1_SRC = 10;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/intc_strobe.sv
// Free-running divider producing a one-cycle pulse every RATIO cycles.
// Assumes RATIO >= 1. The pulse is high in the last count of each period,
// so the first pulse falls in the cycle that completes RATIO cycles after reset.
module intc_strobe #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    // Period counter: wraps to zero after its last count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign pulse = (cnt_q == LAST);

    generate
        if (RATIO > 1) begin : g_gap_chk
            // R5: a pulse is never followed directly by another one.
            p_pulse_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pulse |=> !pulse);
        end
    endgenerate
endmodule

// File: rtl/intc_tick_queue.sv
// Saturating count of timer ticks that have not yet been acknowledged.
// Assumes tick and ack are single-cycle pulses; an ack at zero is dropped.
module intc_tick_queue #(
    parameter int PEND_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    output logic pend_any
);
    localparam logic [PEND_W-1:0] PMAX = '1;

    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] pend_d;
    logic              dec;

    // Next count: ack removes one if any, tick adds one unless at ceiling.
    always_comb begin
        dec = ack && (pend_q != '0);
        unique case ({tick, dec})
            2'b10:   pend_d = (pend_q == PMAX) ? pend_q : pend_q + 1'b1;
            2'b01:   pend_d = pend_q - 1'b1;
            default: pend_d = pend_q;
        endcase
    end

    // Pending count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    assign pend_any = (pend_q != '0);

    // R6: the ceiling holds when only a tick arrives.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ack && pend_q == PMAX) |=> (pend_q == PMAX));

    // R8: a lone acknowledge removes exactly one tick.
    p_ack_takes_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));

    // R8: an acknowledge at zero does not underflow.
    p_ack_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick && pend_q == '0) |=> (pend_q == '0));

    // R5: a lone tick below the ceiling adds one.
    p_tick_adds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ack && pend_q != PMAX) |=> (pend_q == $past(pend_q) + 1'b1));
endmodule

// File: rtl/intc_status.sv
// Status and enable words, timer flag, and the combined interrupt.
// Assumes set/clear inputs are pulses. The timer source bit is rebuilt on each
// evaluation strobe and cleared by its acknowledge; external sets to it are dropped.
module intc_status
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_req,
    input  logic [NSRC-1:0] clr_req,
    input  logic            eval,
    input  logic            tmr0_en,
    input  logic            pend_any,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] status_q,
    output logic [NSRC-1:0] enable_q,
    output logic            tmr0_flag,
    output logic            irq
);
    localparam logic [NSRC-1:0] TMR_MASK = NSRC'(1) << TMR0_SRC;

    logic [NSRC-1:0] status_d;
    logic            tmr_lvl;
    logic [NSRC-1:0] set_ext;

    assign tmr_lvl = tmr0_en && pend_any;
    assign set_ext = set_req & ~TMR_MASK;

    // Per-bit next state: the timer bit follows the strobe, the others set/clear.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_bit
            if (g == TMR0_SRC) begin : g_tmr
                assign status_d[g] = eval        ? tmr_lvl :
                                     clr_req[g]  ? 1'b0    : status_q[g];
            end else begin : g_src
                assign status_d[g] = set_req[g]  ? 1'b1 :
                                     clr_req[g]  ? 1'b0 : status_q[g];
            end
        end
    endgenerate

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= status_d;
    end

    // Enable word register, loaded from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (en_wr)
            enable_q <= en_wdata;
    end

    // Timer flag, refreshed only on evaluation strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr0_flag <= 1'b0;
        else if (eval)
            tmr0_flag <= tmr_lvl;
    end

    assign irq = |(status_q & enable_q);

    // R2: set pulses on ordinary sources always land.
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ext) |=> ((status_q & $past(set_ext)) == $past(set_ext)));

    // R4: an enable write is visible at the next edge.
    p_en_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable_q == $past(en_wdata)));

    // R7: the timer flag is held between strobes.
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(tmr0_flag));

    // R7: after a strobe the timer status bit and the flag agree.
    p_flag_bit_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (status_q[TMR0_SRC] == tmr0_flag));

    // R8: an acknowledge outside a strobe clears the timer bit.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[TMR0_SRC] && !eval) |=> !status_q[TMR0_SRC]);

    // R9: a set pulse cannot raise the timer bit outside a strobe.
    p_tmr_set_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req[TMR0_SRC] && !eval && !status_q[TMR0_SRC]) |=> !status_q[TMR0_SRC]);
endmodule

// File: rtl/tick_queue_intc.sv
// Top of the queued-tick interrupt controller: two strobe dividers (timer tick
// and evaluation), the pending-tick queue and the status/enable block.
// Assumes CLK_HZ is a multiple of TICK_HZ and at least TICK_HZ.
module tick_queue_intc
    import intc_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_HZ  = 100,
    parameter int EVAL_DIV = 16,
    parameter int PEND_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_set,
    input  logic [31:0] src_clr,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tmr0_en,
    output logic        tmr0_flag,
    output logic        cpu_irq
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;

    logic            tick;
    logic            eval;
    logic            pend_any;
    logic            en_wr;
    reg_sel_e        sel;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] enable_q;

    assign sel   = reg_sel_e'(reg_sel);
    assign en_wr = reg_wr && (sel == SEL_ENABLE);

    intc_strobe #(.RATIO(TICK_DIV)) i_tick_div (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (tick)
    );

    intc_strobe #(.RATIO(EVAL_DIV)) i_eval_div (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (eval)
    );

    intc_tick_queue #(.PEND_W(PEND_W)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ack      (src_clr[TMR0_SRC]),
        .pend_any (pend_any)
    );

    intc_status i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (src_set),
        .clr_req   (src_clr),
        .eval      (eval),
        .tmr0_en   (tmr0_en),
        .pend_any  (pend_any),
        .en_wr     (en_wr),
        .en_wdata  (reg_wdata),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .tmr0_flag (tmr0_flag),
        .irq       (cpu_irq)
    );

    // Read mux for the register port.
    always_comb begin
        unique case (sel)
            SEL_ENABLE: reg_rdata = enable_q;
            default:    reg_rdata = status_q;
        endcase
    end

    // R3: with nothing enabled the CPU line stays low.
    p_masked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !cpu_irq);
endmodule

// File: tb/test_tick_queue_intc.sv
// Self-checking bench: a behavioural model of the controller is stepped on
// every rising edge and all outputs are compared on every falling edge.
module test_tick_queue_intc;
    localparam int PERIOD = 10;
    localparam int CLK_HZ = 1000;
    localparam int TICK_HZ = 100;
    localparam int TDIV = CLK_HZ / TICK_HZ;
    localparam int EDIV = 3;
    localparam int PW = 8;
    localparam int PMAX = (1 << PW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_set = '0;
    logic [31:0] src_clr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tmr0_en = 1'b0;
    logic        tmr0_flag;
    logic        cpu_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tick_queue_intc #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .EVAL_DIV(EDIV), .PEND_W(PW)
    ) i_tick_queue_intc (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr0_en(tmr0_en), .tmr0_flag(tmr0_flag),
        .cpu_irq(cpu_irq)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Reference model state
    logic [31:0] m_status = '0;
    logic [31:0] m_en = '0;
    logic        m_flag = 1'b0;
    int          m_pend = 0;
    int          m_tcnt = 0;
    int          m_ecnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0; m_en = '0; m_flag = 1'b0;
            m_pend = 0; m_tcnt = 0; m_ecnt = 0;
        end else begin
            bit tk, ev, ack, lvl;
            int np;
            tk = (m_tcnt == TDIV - 1);
            ev = (m_ecnt == EDIV - 1);
            m_tcnt = tk ? 0 : m_tcnt + 1;
            m_ecnt = ev ? 0 : m_ecnt + 1;
            ack = src_clr[9];
            lvl = tmr0_en && (m_pend > 0);
            np = m_pend;
            if (ack && np > 0) np = np - 1;
            if (tk) np = np + 1;
            if (np > PMAX) np = PMAX;
            for (int i = 0; i < 32; i++) begin
                if (i == 9) begin
                    if (ev) m_status[i] = lvl;
                    else if (ack) m_status[i] = 1'b0;
                end else begin
                    if (src_set[i]) m_status[i] = 1'b1;
                    else if (src_clr[i]) m_status[i] = 1'b0;
                end
            end
            if (ev) m_flag = lvl;
            if (reg_wr && reg_sel) m_en = reg_wdata;
            m_pend = np;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd  = reg_sel ? m_en : m_status;
        exp_irq = |(m_status & m_en);
        chk(cpu_irq === exp_irq, {tag, " R3 cpu_irq"}, {31'd0, cpu_irq}, {31'd0, exp_irq});
        chk(tmr0_flag === m_flag, {tag, " R7 tmr0_flag"}, {31'd0, tmr0_flag}, {31'd0, m_flag});
        chk(reg_rdata === exp_rd, {tag, " R4 reg_rdata"}, reg_rdata, exp_rd);
    endtask

    // One clock: inputs already driven; compare after the edge, then clear pulses.
    task automatic step(input string tag);
        @(negedge clk);
        compare_all(tag);
        src_set = '0;
        src_clr = '0;
        reg_wr  = 1'b0;
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        step("R1");
        chk(reg_rdata === 32'h0, "R1 status after reset", reg_rdata, 32'h0);
        chk(cpu_irq === 1'b0, "R1 irq after reset", {31'd0, cpu_irq}, 32'h0);

        // R2: set, and set with clear together
        src_set[3] = 1'b1; step("R2");
        chk(reg_rdata[3] === 1'b1, "R2 set bit3", reg_rdata, 32'h8);
        src_set[5] = 1'b1; src_clr[5] = 1'b1; src_set[10] = 1'b1; step("R2");
        chk(reg_rdata === 32'h428, "R2 set wins", reg_rdata, 32'h428);
        src_clr[10] = 1'b1; step("R2");

        // R3/R4: enable write, then clears
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h28; step("R4");
        chk(reg_rdata === 32'h28, "R4 enable readback", reg_rdata, 32'h28);
        chk(cpu_irq === 1'b1, "R3 irq raised", {31'd0, cpu_irq}, 32'h1);
        reg_sel = 1'b0; step("R3");
        src_clr[3] = 1'b1; step("R3");
        src_clr[5] = 1'b1; step("R3");
        chk(cpu_irq === 1'b0, "R3 irq dropped", {31'd0, cpu_irq}, 32'h0);

        // R4: write aimed at the status word is ignored
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step("R4");
        chk(reg_rdata === 32'h0, "R4 status write ignored", reg_rdata, 32'h0);

        // R9: set on the timer source is ignored
        src_set[9] = 1'b1; step("R9");
        chk(reg_rdata[9] === 1'b0, "R9 timer bit untouched", reg_rdata, 32'h0);

        // R5/R7: timer enabled, ticks pile up
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_0200; step("R5");
        reg_sel = 1'b0; tmr0_en = 1'b1;
        for (int i = 0; i < 60; i++) step("R5 R7");

        // R8: periodic acknowledges, then drain and ack at zero
        for (int i = 0; i < 80; i++) begin
            if (i % 5 == 0) src_clr[9] = 1'b1;
            step("R8");
        end
        for (int i = 0; i < 60; i++) begin src_clr[9] = 1'b1; step("R8"); end
        for (int i = 0; i < 30; i++) begin
            if (i % 2 == 0) src_clr[9] = 1'b1;
            step("R8");
        end

        // R6: saturate the queue, then drain one per cycle
        for (int i = 0; i < 2700; i++) step("R6");
        for (int i = 0; i < 320; i++) begin src_clr[9] = 1'b1; step("R6"); end

        // R7: timer disabled drops the flag at the next strobe
        for (int i = 0; i < 25; i++) step("R7");
        tmr0_en = 1'b0;
        for (int i = 0; i < 25; i++) step("R7");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            src_set = $urandom() & $urandom() & $urandom();
            src_clr = $urandom() & $urandom() & $urandom();
            src_clr[9] = ($urandom() % 4 == 0);
            reg_sel = $urandom() % 2;
            reg_wr = ($urandom() % 8 == 0);
            reg_wdata = $urandom();
            if ($urandom() % 50 == 0) tmr0_en = ~tmr0_en;
            step("R2 R8 mixed");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule